// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor that keeps all working data in one accumulator. Each instruction names a single memory operand. The accumulator is always both the implied source and the implied destination. Every instruction passes through fetch, decode and execute as a fixed chain of one-cycle register transfers between the program counter, instruction register, memory address register, memory data register and accumulator. Memory accesses sit between these transfers, and each access holds the memory port for a fixed number of cycles.

Because every step has a fixed length, an instruction's cost depends only on its class. The core also reports how many cycles it ran before halting. A testbench or system model can therefore count the exact cost of a known program. The memory is external and is addressed by byte. A request stays high for the whole access. A last-cycle strobe marks the edge at which read data is captured into the memory data register, or at which the memory must commit a write.

Top module: `accCore`

## Requirements
- R1: While reset is asserted and directly after it, `halted` is 0, `cycleCount` is 0 and `memReq` is 0. The first fetch reads byte address 0.
- R2: Every memory access holds `memReq` high for exactly MEM_LAT consecutive cycles (10 by default) with a constant `memWe` and `memAddr`. `memLast` is high only in the final cycle of an access.
- R3: Fetch takes 1 cycle to load the address register from the program counter, then one MEM_LAT read, then 1 cycle that loads the instruction register and adds 2 to the program counter. Fetches therefore read consecutive even addresses.
- R4: Decode lasts DEC_CYCLES cycles (2 by default). With default values the cost of an instruction is fixed by its class: 26 cycles for a load or arithmetic instruction and 25 cycles for a store. Between the end of a fetch and the start of its operand access, `memReq` is low for 4 cycles. Before the next fetch, `memReq` is low for 2 cycles after an operand read and for 1 cycle after a write.
- R5: The instruction word has the opcode in bits [15:12] and the operand byte address in bits [11:0]. The opcodes are STOP=0, LD=1, ST=2, ADD=3, SUB=4, MULT=5. The operand access goes to the address field.
- R6: LD loads the accumulator with the memory word at the operand address.
- R7: ADD and SUB compute accumulator plus or minus the operand and wrap modulo 2^16.
- R8: MULT keeps the low 16 bits of the product of the accumulator and the operand.
- R9: ST writes the accumulator to the operand address with `memWe` high, and the write data stays constant through the access. The accumulator is not changed by the store.
- R10: STOP halts the core 14 cycles after its fetch begins. After that, `halted` stays 1 and `memReq` stays 0.
- R11: Opcodes 6 to 15 halt the core in the same way as STOP.
- R12: `cycleCount` counts every clock cycle from reset release until the core halts, then holds. The program a=(x+y)*(x-y) (LD, ADD, ST, LD, SUB, MULT, ST, STOP) totals 194 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 12 | Byte address from the memory address register |
| memWrData | output | 16 | Write data from the memory data register |
| memRdData | input | 16 | Read data from memory, valid while `memReq` is high and `memWe` is low |
| memReq | output | 1 | Memory access in progress |
| memWe | output | 1 | The access is a write |
| memLast | output | 1 | Final cycle of the access: read data is captured, or the write must be committed |
| halted | output | 1 | Core is stopped |
| cycleCount | output | 32 | Cycles executed since reset release |

## Verification
The bench builds the core with its defaults: 16-bit words, a 10-cycle memory latency and a 2-cycle decode. With these values the stated 12-cycle fetch applies, along with the exact totals of 26, 25 and 14 cycles per instruction class, so whole-program cycle totals can be predicted by hand. The 16-bit data width lets short operand values drive ADD, SUB and MULT past their wrap points. The 12-bit address field lets the bench place code and data in separate regions. A scoreboard predicts every memory access in order, including its kind, address, store data, length and the idle gap before it.

// File: rtl/accPkg.sv
`timescale 1ns/1ps
package accPkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_STOP = 4'd0,
    OP_LD   = 4'd1,
    OP_ST   = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_MULT = 4'd5
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_MUL  = 2'd3
  } aluSel_e;

  typedef enum logic [3:0] {
    S_FMAR, S_FRD, S_FIR, S_DEC, S_XMAR, S_XRD, S_XALU, S_XWR, S_HALT
  } state_e;

  // One-cycle transfer strobes from control to datapath
  typedef struct packed {
    logic    marFromPc;
    logic    marFromIr;
    logic    mdrFromMem;
    logic    mdrFromAcc;
    logic    irFromMdr;
    logic    pcInc;
    logic    accLoad;
    aluSel_e aluSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/accAlu.sv
`timescale 1ns/1ps
module accAlu
  import accPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluSel_e             sel,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   operand,
  output logic [DATA_W-1:0]   result
);
  logic [2*DATA_W-1:0] product;

  assign product = {{DATA_W{1'b0}}, accIn} * {{DATA_W{1'b0}}, operand};

  always_comb begin
    unique case (sel)
      ALU_PASS: result = operand;
      ALU_ADD:  result = accIn + operand;
      ALU_SUB:  result = accIn - operand;
      ALU_MUL:  result = product[DATA_W-1:0];
      default:  result = operand;
    endcase
  end
endmodule

// File: rtl/accDatapath.sv
`timescale 1ns/1ps
module accDatapath
  import accPkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [ADDR_W-1:0]  marOut,
  output logic [DATA_W-1:0]  mdrOut,
  output logic [OPC_W-1:0]   opcode,
  output logic [ADDR_W-1:0]  pcOut
);
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] aluRes;

  accAlu #(.DATA_W(DATA_W)) alu (
    .sel     (strb.aluSel),
    .accIn   (acc),
    .operand (mdr),
    .result  (aluRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      mar <= '0;
      ir  <= '0;
      mdr <= '0;
      acc <= '0;
    end else begin
      if (strb.marFromPc)       mar <= pc;
      else if (strb.marFromIr)  mar <= ir[ADDR_W-1:0];
      if (strb.mdrFromMem)      mdr <= memRdData;
      else if (strb.mdrFromAcc) mdr <= acc;
      if (strb.irFromMdr)       ir  <= mdr;
      if (strb.pcInc)           pc  <= pc + ADDR_W'(2);
      if (strb.accLoad)         acc <= aluRes;
    end
  end

  assign marOut = mar;
  assign mdrOut = mdr;
  assign opcode = ir[DATA_W-1 -: OPC_W];
  assign pcOut  = pc;

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.irFromMdr |=> pc == $past(pc) + ADDR_W'(2));

  // R5
  src_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.marFromPc, strb.marFromIr}) && $onehot0({strb.mdrFromMem, strb.mdrFromAcc}));
endmodule

// File: rtl/accCtrl.sv
`timescale 1ns/1ps
module accCtrl
  import accPkg::*;
#(
  parameter int MEM_LAT    = 10,
  parameter int DEC_CYCLES = 2,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPC_W-1:0]  opcode,
  output ctrlStrobes_t      strb,
  output logic              memReq,
  output logic              memWe,
  output logic              memLast,
  output logic              halted,
  output logic [CNT_W-1:0]  cycleCount
);
  localparam int LAT_MAX = (MEM_LAT > DEC_CYCLES) ? MEM_LAT : DEC_CYCLES;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);
  localparam logic [LAT_W-1:0] MEM_END = LAT_W'(MEM_LAT - 1);
  localparam logic [LAT_W-1:0] DEC_END = LAT_W'(DEC_CYCLES - 1);

  state_e           state, nextState;
  logic [LAT_W-1:0] latCnt;
  logic             timed;
  logic             atEnd;
  logic             isStore;
  logic             isExec;
  aluSel_e          opAlu;

  // Opcode classes
  always_comb begin
    isStore = 1'b0;
    isExec  = 1'b0;
    opAlu   = ALU_PASS;
    case (opcode)
      OP_LD:   isExec = 1'b1;
      OP_ST:   isStore = 1'b1;
      OP_ADD:  begin isExec = 1'b1; opAlu = ALU_ADD; end
      OP_SUB:  begin isExec = 1'b1; opAlu = ALU_SUB; end
      OP_MULT: begin isExec = 1'b1; opAlu = ALU_MUL; end
      default: ;
    endcase
  end

  assign timed = (state == S_FRD) || (state == S_XRD) || (state == S_XWR) || (state == S_DEC);
  assign atEnd = (state == S_DEC) ? (latCnt == DEC_END) : (latCnt == MEM_END);

  always_comb begin
    nextState = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memLast   = 1'b0;
    unique case (state)
      S_FMAR: begin
        strb.marFromPc = 1'b1;
        nextState      = S_FRD;
      end
      S_FRD: begin
        memReq  = 1'b1;
        memLast = atEnd;
        if (atEnd) begin
          strb.mdrFromMem = 1'b1;
          nextState       = S_FIR;
        end
      end
      S_FIR: begin
        strb.irFromMdr = 1'b1;
        strb.pcInc     = 1'b1;
        nextState      = S_DEC;
      end
      S_DEC: begin
        if (atEnd) begin
          if (isStore || isExec) nextState = S_XMAR;
          else                   nextState = S_HALT;
        end
      end
      S_XMAR: begin
        strb.marFromIr = 1'b1;
        if (isStore) begin
          strb.mdrFromAcc = 1'b1;
          nextState       = S_XWR;
        end else begin
          nextState = S_XRD;
        end
      end
      S_XRD: begin
        memReq  = 1'b1;
        memLast = atEnd;
        if (atEnd) begin
          strb.mdrFromMem = 1'b1;
          nextState       = S_XALU;
        end
      end
      S_XALU: begin
        strb.accLoad = 1'b1;
        strb.aluSel  = opAlu;
        nextState    = S_FMAR;
      end
      S_XWR: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        memLast = atEnd;
        if (atEnd) nextState = S_FMAR;
      end
      S_HALT: nextState = S_HALT;
      default: nextState = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_FMAR;
      latCnt     <= '0;
      cycleCount <= '0;
    end else begin
      state <= nextState;
      if (timed && !atEnd) latCnt <= latCnt + LAT_W'(1);
      else                 latCnt <= '0;
      if (state != S_HALT) cycleCount <= cycleCount + CNT_W'(1);
    end
  end

  assign halted = (state == S_HALT);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memLast |=> memReq && $stable(memWe));

  // R2
  last_in_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memLast |-> memReq);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && !memReq);

  // R12
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(cycleCount));
endmodule

// File: rtl/accCore.sv
`timescale 1ns/1ps
module accCore
  import accPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MEM_LAT    = 10,
  parameter int DEC_CYCLES = 2,
  parameter int CNT_W      = 32,
  localparam int ADDR_W    = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memReq,
  output logic              memWe,
  output logic              memLast,
  output logic              halted,
  output logic [CNT_W-1:0]  cycleCount
);
  ctrlStrobes_t      strb;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] pcOut;

  accCtrl #(
    .MEM_LAT    (MEM_LAT),
    .DEC_CYCLES (DEC_CYCLES),
    .CNT_W      (CNT_W)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opcode     (opcode),
    .strb       (strb),
    .memReq     (memReq),
    .memWe      (memWe),
    .memLast    (memLast),
    .halted     (halted),
    .cycleCount (cycleCount)
  );

  accDatapath #(.DATA_W(DATA_W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .memRdData (memRdData),
    .marOut    (memAddr),
    .mdrOut    (memWrData),
    .opcode    (opcode),
    .pcOut     (pcOut)
  );

  // R9
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !memLast |=> $stable(memWrData) && $stable(memAddr));

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.marFromPc |=> memAddr == pcOut);
endmodule

// File: tb/accCore_test.sv
`timescale 1ns/1ps
module accCore_test;
  localparam int DW  = 16;
  localparam int AW  = 12;
  localparam int LAT = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData;
  logic [DW-1:0] memRdData;
  logic          memReq, memWe, memLast, halted;
  logic [31:0]   cycleCount;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] mem [0:(1<<(AW-1))-1];

  typedef struct {
    int            kind;   // 0 fetch, 1 operand read, 2 write
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            gap;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int prevKind = -1;
  int idleCnt  = 0;
  int runCnt   = 0;

  always #10 clk = ~clk;

  accCore uut (
    .clk        (clk),
    .rstN       (rstN),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memRdData  (memRdData),
    .memReq     (memReq),
    .memWe      (memWe),
    .memLast    (memLast),
    .halted     (halted),
    .cycleCount (cycleCount)
  );

  assign memRdData = mem[memAddr[AW-1:1]];

  always @(posedge clk)
    if (memReq && memWe && memLast) mem[memAddr[AW-1:1]] <= memWrData;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input int op, input int addr);
    return {4'(op), 12'(addr)};
  endfunction

  // Driver: push one expected access, gap derived from R4
  task automatic expAcc(input int kind, input int addr, input int data, input string tag);
    expItem_t it;
    it.kind = kind;
    it.addr = AW'(addr);
    it.data = DW'(data);
    it.tag  = tag;
    if (kind == 0) it.gap = (prevKind == 1) ? 2 : 1;
    else           it.gap = 4;
    prevKind = kind;
    expQ.push_back(it);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rstN) begin
      idleCnt = 0;
      runCnt  = 0;
    end else if (memReq) begin
      runCnt++;
      if (memLast) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected access", memAddr, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(memAddr == it.addr, (it.kind == 0) ? "R3 fetch address" : "R5 operand address",
                memAddr, it.addr);
          check(memWe == (it.kind == 2), "R9 access kind", memWe, it.kind == 2);
          check(runCnt == LAT, "R2 access length", runCnt, LAT);
          check(idleCnt == it.gap, "R4 idle gap", idleCnt, it.gap);
          if (it.kind == 2) check(memWrData == it.data, it.tag, memWrData, it.data);
        end
        runCnt  = 0;
        idleCnt = 0;
      end
    end else begin
      idleCnt++;
    end
  end

  task automatic holdReset();
    @(posedge clk); #1 rstN = 1'b0;
    expQ.delete();
    prevKind = -1;
    repeat (2) @(posedge clk);
    #1;
    check(halted == 1'b0, "R1 halted in reset", halted, 0);
    check(cycleCount == 0, "R1 count in reset", cycleCount, 0);
    check(memReq == 1'b0, "R1 no request in reset", memReq, 0);
  endtask

  task automatic runProg(input int expCycles, input string cycTag);
    int   held;
    logic [31:0] cnt;
    @(posedge clk); #1 rstN = 1'b1;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    check(halted == 1'b1, "R10 halted reached", halted, 1);
    check(cycleCount == expCycles, cycTag, cycleCount, expCycles);
    cnt  = cycleCount;
    held = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (memReq || !halted) held++;
    end
    check(held == 0, "R10 quiet after halt", held, 0);
    check(cycleCount == cnt, "R12 count holds", cycleCount, cnt);
    check(expQ.size() == 0, "R3 all accesses seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << (AW-1)); i++) mem[i] = '0;

    // Program 1: a = (x+y)*(x-y), x=300 y=500 (R7, R8, R12)
    holdReset();
    mem[0] = ins(1, 'h100); mem[1] = ins(3, 'h102); mem[2] = ins(2, 'h104);
    mem[3] = ins(1, 'h100); mem[4] = ins(4, 'h102); mem[5] = ins(5, 'h104);
    mem[6] = ins(2, 'h106); mem[7] = ins(0, 0);
    mem['h80] = 16'd300; mem['h81] = 16'd500;
    expAcc(0, 0, 0, "");   expAcc(1, 'h100, 0, "");
    expAcc(0, 2, 0, "");   expAcc(1, 'h102, 0, "");
    expAcc(0, 4, 0, "");   expAcc(2, 'h104, 800, "R7 add result");
    expAcc(0, 6, 0, "");   expAcc(1, 'h100, 0, "");
    expAcc(0, 8, 0, "");   expAcc(1, 'h102, 0, "");
    expAcc(0, 10, 0, "");  expAcc(1, 'h104, 0, "");
    expAcc(0, 12, 0, "");  expAcc(2, 'h106, int'(16'(800 * (300 - 500))), "R8 multiply low bits");
    expAcc(0, 14, 0, "");
    runProg(194, "R12 program total");
    check(mem['h83] == 16'h8F00, "R8 stored product", mem['h83], 16'h8F00);

    // Program 2: add/sub wrap, repeated store, illegal opcode (R7, R9, R11)
    holdReset();
    mem[0] = ins(1, 'h200); mem[1] = ins(3, 'h202); mem[2] = ins(2, 'h210);
    mem[3] = ins(2, 'h212); mem[4] = ins(4, 'h202); mem[5] = ins(2, 'h214);
    mem[6] = 16'h7ABC;
    mem['h100] = 16'hFFF0; mem['h101] = 16'h0020;
    expAcc(0, 0, 0, "");   expAcc(1, 'h200, 0, "");
    expAcc(0, 2, 0, "");   expAcc(1, 'h202, 0, "");
    expAcc(0, 4, 0, "");   expAcc(2, 'h210, 'h0010, "R7 add wrap");
    expAcc(0, 6, 0, "");   expAcc(2, 'h212, 'h0010, "R9 acc kept by store");
    expAcc(0, 8, 0, "");   expAcc(1, 'h202, 0, "");
    expAcc(0, 10, 0, "");  expAcc(2, 'h214, 'hFFF0, "R7 sub wrap");
    expAcc(0, 12, 0, "");
    runProg(167, "R11 illegal opcode halt total");

    // Program 3: STOP with nonzero address field (R10)
    holdReset();
    mem[0] = 16'h0FFF;
    expAcc(0, 0, 0, "");
    runProg(14, "R10 stop cost");

    // Program 4: load then store, then opcode 15 (R6, R11)
    holdReset();
    mem[0] = ins(1, 'h300); mem[1] = ins(2, 'h302); mem[2] = 16'hF123;
    mem['h180] = 16'hBEEF; mem['h181] = 16'h0000;
    expAcc(0, 0, 0, "");   expAcc(1, 'h300, 0, "");
    expAcc(0, 2, 0, "");   expAcc(2, 'h302, 'hBEEF, "R6 load value");
    expAcc(0, 4, 0, "");
    runProg(65, "R4 class totals");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule